// File: doc/BRIEF.md
# Debug Halt Mode Controller

This block parks a processor core in a static debug halt, where fetch and decode stop and nothing is issued except what a debugger supplies. It also brings the core back to normal run. A halt can be requested in three ways: a decoded "begin halt" command from the debug port, an active-low run/stop pin driven by external hardware, or an internal debug-exception pulse. The exception pulse only counts when the halt-enable control bit is set.

The block records which path caused the halt, because that path decides how the halt may end. A halt entered through the pin ends only when the pin returns high. A halt entered by command or by exception ends on an "end halt" command, or on a full high-low-high cycle of the pin. While a halt is pending or active, the block raises a hold-off output. The interrupt logic uses it to defer pending exceptions, NMI and external interrupts until the core runs again.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: A `cmd_begin_i` pulse in run moves the block to a draining phase. `halt_o` and `ready_o` rise in the cycle after the first cycle, at or after the request, in which `insn_boundary_i` is high. `entry_src_o` then reads 2'b01.
- R2: `run_stop_n_i` passes through two synchronizing flops. A low level, seen after synchronization, requests a halt that also waits for an instruction boundary. `entry_src_o` then reads 2'b10.
- R3: In a halt entered through the pin, `cmd_end_i` has no effect. Only a synchronized low-to-high edge of `run_stop_n_i` ends the halt.
- R4: In a halt entered by command (2'b01) or by exception (2'b11), `cmd_end_i` ends the halt.
- R5: In a halt entered by command or by exception, a pin fall followed by a pin rise also ends the halt. The exit is accepted on the synchronized rising edge; the falling edge alone leaves the core halted.
- R6: When `dbg_halt_en_i` is high, any set bit of `exc_src_i` halts the core in the next cycle, with no boundary wait, and sets `entry_src_o` to 2'b11. The five source bits stand for breakpoint match, single step, task-switch trap, guarded debug-register access and breakpoint instruction. When `dbg_halt_en_i` is low, the pulse is ignored.
- R7: `irq_holdoff_o` is high whenever a halt is draining or active, and low in run.
- R8: `ready_o` falls in the same cycle an exit is accepted. `halt_o` falls one cycle later, and `entry_src_o` returns to 2'b00 at the same time.
- R9: When requests arrive in the same cycle, pin beats exception and exception beats command.
- R10: While halted, further begin commands and exception pulses are ignored and `entry_src_o` does not change.
- R11: After reset, `halt_o`, `ready_o` and `irq_holdoff_o` are low and `entry_src_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_begin_i | input | 1 | Decoded "begin halt" command pulse |
| cmd_end_i | input | 1 | Decoded "end halt" command pulse |
| run_stop_n_i | input | 1 | Asynchronous run/stop pin, low requests halt |
| exc_src_i | input | NUM_EXC | Debug-exception source pulses |
| dbg_halt_en_i | input | 1 | Enable bit from the halt control register |
| insn_boundary_i | input | 1 | Core is at an instruction boundary |
| halt_o | output | 1 | Stall fetch and decode |
| ready_o | output | 1 | Core accepts debug commands |
| entry_src_o | output | 2 | Entry path: 00 none, 01 command, 10 pin, 11 exception |
| irq_holdoff_o | output | 1 | Defer exceptions, NMI and interrupts |

## Verification
The assertions assume that the core eventually raises `insn_boundary_i` after a request. They also assume that `run_stop_n_i` is held high while the core runs, unless a pin halt is meant. The stimulus respects both. It pulses `insn_boundary_i` inside each draining window, and it only lowers the pin when it intends a pin entry or a pin-cycle exit. Simultaneous requests are placed in the exact cycle in which the synchronized pin level first reads low, so the priority rule is exercised at its edge.

// File: rtl/dbg_halt_pkg.sv
// Package: shared types for the debug halt controller.
// Assumes: nothing; pure type definitions.
package dbg_halt_pkg;

    // Entry path encoding, visible on entry_src_o
    typedef enum logic [1:0] {
        SRC_NONE = 2'b00,
        SRC_CMD  = 2'b01,
        SRC_PIN  = 2'b10,
        SRC_EXC  = 2'b11
    } entry_src_e;

    // Controller phase
    typedef enum logic [1:0] {
        ST_RUN   = 2'b00,
        ST_DRAIN = 2'b01,
        ST_HALT  = 2'b10
    } halt_state_e;

endpackage

// File: rtl/dbg_pin_sync.sv
// Module: dbg_pin_sync
// Brings the asynchronous run/stop pin into the clock domain through a
// chain of STAGES flops, then reports the level and single-cycle edges.
// Assumes: pin idles high; flops reset to the idle level.
module dbg_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;
    logic          prev_q;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("dbg_pin_sync needs at least two stages");
        end
    endgenerate

    // Shift the pin through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[LAST-1:0], pin_async_i};
    end

    // Remember last synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[LAST];
    end

    // Level and edges seen after synchronization
    always_comb begin
        level_o = chain_q[LAST];
        rise_o  = chain_q[LAST] & ~prev_q;
        fall_o  = ~chain_q[LAST] & prev_q;
    end

endmodule

// File: rtl/dbg_exc_gate.sv
// Module: dbg_exc_gate
// Merges the debug-exception source pulses into one halt request,
// qualified by the halt-enable control bit.
// Assumes: each source bit is a synchronous pulse in the core clock domain.
module dbg_exc_gate #(
    parameter int NUM_EXC = 5
) (
    input  logic [NUM_EXC-1:0] src_i,
    input  logic               enable_i,
    output logic               hit_o
);

    // Any qualifying source, only when enabled
    always_comb begin
        hit_o = enable_i & (|src_i);
    end

endmodule

// File: rtl/dbg_halt_fsm.sv
// Module: dbg_halt_fsm
// Sequences run -> drain -> halt -> run, records the entry path and
// selects the exit rule that path allows.
// Assumes: pin inputs are synchronized; command and exception are pulses.
module dbg_halt_fsm
    import dbg_halt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_begin_i,
    input  logic       cmd_end_i,
    input  logic       pin_hi_i,
    input  logic       pin_rise_i,
    input  logic       pin_fall_i,
    input  logic       exc_hit_i,
    input  logic       boundary_i,
    output logic       halt_o,
    output logic       ready_o,
    output entry_src_e src_o,
    output logic       holdoff_o
);

    halt_state_e state_q, state_d;
    entry_src_e  src_q, src_d;
    logic        armed_q, armed_d;
    logic        exit_now;

    // Exit acceptance: rule depends on how the halt was entered
    always_comb begin
        exit_now = 1'b0;
        if (state_q == ST_HALT) begin
            if (src_q == SRC_PIN) exit_now = pin_rise_i;
            else                  exit_now = cmd_end_i | (pin_rise_i & armed_q);
        end
    end

    // Next phase, entry path and pin-cycle arming
    always_comb begin
        state_d = state_q;
        src_d   = src_q;
        armed_d = armed_q;
        unique case (state_q)
            ST_RUN: begin
                armed_d = 1'b0;
                if (!pin_hi_i) begin
                    src_d   = SRC_PIN;
                    state_d = boundary_i ? ST_HALT : ST_DRAIN;
                end else if (exc_hit_i) begin
                    src_d   = SRC_EXC;
                    state_d = ST_HALT;
                end else if (cmd_begin_i) begin
                    src_d   = SRC_CMD;
                    state_d = boundary_i ? ST_HALT : ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (boundary_i) state_d = ST_HALT;
            end
            ST_HALT: begin
                if (exit_now) begin
                    state_d = ST_RUN;
                    src_d   = SRC_NONE;
                    armed_d = 1'b0;
                end else if (pin_fall_i) begin
                    armed_d = 1'b1;
                end
            end
            default: begin
                state_d = ST_RUN;
                src_d   = SRC_NONE;
                armed_d = 1'b0;
            end
        endcase
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            src_q   <= SRC_NONE;
            armed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
            armed_q <= armed_d;
        end
    end

    // Outputs: ready drops combinationally on the exit cycle
    always_comb begin
        halt_o    = (state_q == ST_HALT);
        ready_o   = (state_q == ST_HALT) & ~exit_now;
        holdoff_o = (state_q != ST_RUN);
        src_o     = src_q;
    end

endmodule

// File: rtl/dbg_halt_ctrl.sv
// Module: dbg_halt_ctrl (top)
// Debug halt controller: joins the pin synchronizer, the exception gate
// and the halt sequencer.
// Assumes: run_stop_n_i may be asynchronous; all other inputs are
// synchronous to clk.
module dbg_halt_ctrl
    import dbg_halt_pkg::*;
#(
    parameter int NUM_EXC     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_begin_i,
    input  logic               cmd_end_i,
    input  logic               run_stop_n_i,
    input  logic [NUM_EXC-1:0] exc_src_i,
    input  logic               dbg_halt_en_i,
    input  logic               insn_boundary_i,
    output logic               halt_o,
    output logic               ready_o,
    output logic [1:0]         entry_src_o,
    output logic               irq_holdoff_o
);

    logic       pin_hi_s;
    logic       pin_rise;
    logic       pin_fall;
    logic       exc_hit;
    entry_src_e src;

    dbg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_async_i(run_stop_n_i),
        .level_o    (pin_hi_s),
        .rise_o     (pin_rise),
        .fall_o     (pin_fall)
    );

    dbg_exc_gate #(.NUM_EXC(NUM_EXC)) u_gate (
        .src_i   (exc_src_i),
        .enable_i(dbg_halt_en_i),
        .hit_o   (exc_hit)
    );

    dbg_halt_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_begin_i(cmd_begin_i),
        .cmd_end_i  (cmd_end_i),
        .pin_hi_i   (pin_hi_s),
        .pin_rise_i (pin_rise),
        .pin_fall_i (pin_fall),
        .exc_hit_i  (exc_hit),
        .boundary_i (insn_boundary_i),
        .halt_o     (halt_o),
        .ready_o    (ready_o),
        .src_o      (src),
        .holdoff_o  (irq_holdoff_o)
    );

    // Present the entry path as a plain vector
    always_comb begin
        entry_src_o = src;
    end

endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
// Module: dbg_halt_ctrl_chk
// Property checker for dbg_halt_ctrl, attached by bind.
// Assumes: the same clock and reset as the controller.
module dbg_halt_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       insn_boundary_i,
    input logic       halt_o,
    input logic       ready_o,
    input logic [1:0] entry_src_o,
    input logic       irq_holdoff_o,
    input logic       pin_hi_s,
    input logic       pin_rise,
    input logic       exc_hit
);

    // Command-entered halt starts only after a boundary cycle
    assert_boundary_before_halt_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(halt_o) && entry_src_o == 2'b01) |-> $past(insn_boundary_i));

    // Pin-entered halt stays ready until a pin rise
    assert_pin_only_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_o && entry_src_o == 2'b10 && !pin_rise) |-> ready_o);

    // Enabled exception from run halts at once
    assert_exc_immediate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_holdoff_o && exc_hit && pin_hi_s) |=> (halt_o && entry_src_o == 2'b11));

    // Hold-off covers every halt cycle and tracks the entry path
    assert_holdoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_o |-> irq_holdoff_o) and ((entry_src_o == 2'b00) == !irq_holdoff_o));

    // Ready never without halt
    assert_ready_needs_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> halt_o);

    // Exit cycle is followed by release and cleared entry path
    assert_release_after_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_o && !ready_o) |=> (!halt_o && entry_src_o == 2'b00));

    // Pin request wins over any other request in run
    assert_pin_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_holdoff_o && !pin_hi_s) |=> (entry_src_o == 2'b10));

    // Entry path frozen while halted
    assert_src_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> (!halt_o || $stable(entry_src_o)));

endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .insn_boundary_i(insn_boundary_i),
    .halt_o         (halt_o),
    .ready_o        (ready_o),
    .entry_src_o    (entry_src_o),
    .irq_holdoff_o  (irq_holdoff_o),
    .pin_hi_s       (pin_hi_s),
    .pin_rise       (pin_rise),
    .exc_hit        (exc_hit)
);

// File: tb/dbg_halt_ctrl_tb.sv
// Bench for dbg_halt_ctrl: vector table walk, then directed cases.
module dbg_halt_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cb, ce, pn, en, bnd;
    logic [4:0] exc;
    logic       halt_o, ready_o, irq_holdoff_o;
    logic [1:0] entry_src_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dbg_halt_ctrl u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_begin_i    (cb),
        .cmd_end_i      (ce),
        .run_stop_n_i   (pn),
        .exc_src_i      (exc),
        .dbg_halt_en_i  (en),
        .insn_boundary_i(bnd),
        .halt_o         (halt_o),
        .ready_o        (ready_o),
        .entry_src_o    (entry_src_o),
        .irq_holdoff_o  (irq_holdoff_o)
    );

    // Columns: cb ce pn exc en bnd | halt ready src hold | req
    localparam int NV = 47;
    localparam int VEC [NV][11] = '{
        '{0,0,1, 0,0,0, 0,0,0,0, 11}, // v0  idle after reset R11
        '{1,0,1, 0,0,0, 0,0,0,0, 1},  // v1  begin, no boundary R1
        '{0,0,1, 0,0,0, 0,0,1,1, 1},  // v2  draining R1 R7
        '{0,0,1, 0,0,1, 0,0,1,1, 1},  // v3  boundary seen
        '{0,0,1, 0,0,0, 1,1,1,1, 1},  // v4  halted by command R1
        '{0,1,1, 0,0,0, 1,0,1,1, 4},  // v5  end command exits R4 R8
        '{0,0,1, 0,0,0, 0,0,0,0, 8},  // v6  released R8
        '{0,0,1, 4,0,0, 0,0,0,0, 6},  // v7  exception, disabled R6
        '{0,0,1, 0,0,0, 0,0,0,0, 6},  // v8  ignored R6
        '{0,0,1, 1,1,0, 0,0,0,0, 6},  // v9  exception enabled R6
        '{1,0,1, 0,0,0, 1,1,3,1, 10}, // v10 begin while halted R10
        '{0,0,1, 2,1,0, 1,1,3,1, 10}, // v11 exception while halted R10
        '{0,0,0, 0,0,0, 1,1,3,1, 5},  // v12 pin low
        '{0,0,0, 0,0,0, 1,1,3,1, 5},  // v13
        '{0,0,0, 0,0,0, 1,1,3,1, 5},  // v14 fall seen, still halted R5
        '{0,0,1, 0,0,0, 1,1,3,1, 5},  // v15 pin high
        '{0,0,1, 0,0,0, 1,1,3,1, 5},  // v16
        '{0,0,1, 0,0,0, 1,0,3,1, 5},  // v17 rise accepted R5 R8
        '{0,0,1, 0,0,0, 0,0,0,0, 8},  // v18
        '{0,0,0, 0,0,1, 0,0,0,0, 2},  // v19 pin low R2
        '{0,0,0, 0,0,1, 0,0,0,0, 2},  // v20 sync stage
        '{0,0,0, 0,0,1, 0,0,0,0, 2},  // v21 synced low, boundary
        '{0,1,0, 0,0,0, 1,1,2,1, 3},  // v22 end command ignored R3
        '{0,1,0, 0,0,0, 1,1,2,1, 3},  // v23 still halted R3
        '{0,0,1, 0,0,0, 1,1,2,1, 3},  // v24 pin high
        '{0,1,1, 0,0,0, 1,1,2,1, 3},  // v25 end ignored again R3
        '{0,0,1, 0,0,0, 1,0,2,1, 3},  // v26 rise exits R3
        '{0,0,1, 0,0,0, 0,0,0,0, 8},  // v27
        '{0,0,0, 0,0,0, 0,0,0,0, 9},  // v28 pin low, no boundary
        '{0,0,0, 0,0,0, 0,0,0,0, 9},  // v29
        '{1,0,0,16,1,0, 0,0,0,0, 9},  // v30 all three at once R9
        '{0,0,0, 0,0,0, 0,0,2,1, 9},  // v31 pin won R9
        '{0,0,0, 0,0,1, 0,0,2,1, 2},  // v32 boundary
        '{0,0,1, 0,0,0, 1,1,2,1, 2},  // v33 halted by pin R2
        '{0,0,1, 0,0,0, 1,1,2,1, 3},  // v34
        '{0,0,1, 0,0,0, 1,0,2,1, 3},  // v35 rise exits
        '{0,0,1, 0,0,0, 0,0,0,0, 8},  // v36
        '{1,0,1, 8,1,0, 0,0,0,0, 9},  // v37 exception and command R9
        '{0,0,1, 0,0,0, 1,1,3,1, 9},  // v38 exception won R9
        '{0,1,1, 0,0,0, 1,0,3,1, 4},  // v39 end command R4
        '{0,0,1, 0,0,0, 0,0,0,0, 8},  // v40
        '{1,0,1, 0,0,1, 0,0,0,0, 1},  // v41 begin at boundary R1
        '{0,0,1, 0,0,0, 1,1,1,1, 1},  // v42 halted next cycle
        '{0,0,0, 0,0,0, 1,1,1,1, 5},  // v43 pin cycle on command halt R5
        '{0,0,1, 0,0,0, 1,1,1,1, 5},  // v44
        '{0,0,1, 0,0,0, 1,1,1,1, 5},  // v45 fall seen here
        '{0,0,1, 0,0,0, 1,0,1,1, 5}   // v46 rise exits R5
    };

    task automatic check(string req, logic h, logic r, logic [1:0] s, logic hd);
        checks++;
        if (halt_o !== h || ready_o !== r || entry_src_o !== s || irq_holdoff_o !== hd) begin
            errors++;
            $display("FAIL %s got halt=%b ready=%b src=%b hold=%b exp halt=%b ready=%b src=%b hold=%b",
                     req, halt_o, ready_o, entry_src_o, irq_holdoff_o, h, r, s, hd);
        end
    endtask

    task automatic idle_inputs();
        cb = 0; ce = 0; pn = 1; en = 0; bnd = 0; exc = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: drive at falling edge, check before rising edge
        for (int i = 0; i < NV; i++) begin
            if (i > 0) @(negedge clk);
            cb  = (VEC[i][0] != 0);
            ce  = (VEC[i][1] != 0);
            pn  = (VEC[i][2] != 0);
            exc = 5'(VEC[i][3]);
            en  = (VEC[i][4] != 0);
            bnd = (VEC[i][5] != 0);
            #1;
            check($sformatf("R%0d v%0d", VEC[i][10], i), VEC[i][6] != 0, VEC[i][7] != 0,
                  2'(VEC[i][8]), VEC[i][9] != 0);
        end
        @(negedge clk); idle_inputs(); #1;
        check("R8 tail", 0, 0, 2'b00, 0);

        // R6: each exception source alone halts when enabled
        for (int b = 0; b < 5; b++) begin
            @(negedge clk); idle_inputs(); exc = 5'(1 << b); en = 1; #1;
            check("R6 source pre", 0, 0, 2'b00, 0);
            @(negedge clk); idle_inputs(); #1;
            check("R6 source halts", 1, 1, 2'b11, 1);
            @(negedge clk); ce = 1; #1;
            check("R4 exit", 1, 0, 2'b11, 1);
            @(negedge clk); idle_inputs(); #1;
            check("R8 release", 0, 0, 2'b00, 0);
        end

        // R4: end command in run has no effect
        @(negedge clk); idle_inputs(); ce = 1;
        @(negedge clk); idle_inputs(); #1;
        check("R4 end in run", 0, 0, 2'b00, 0);

        // R11: reset while halted
        @(negedge clk); exc = 5'b00001; en = 1;
        @(negedge clk); idle_inputs(); #1;
        check("R11 pre-reset halt", 1, 1, 2'b11, 1);
        rst_n = 1'b0;
        @(negedge clk); #1;
        check("R11 reset clears", 0, 0, 2'b00, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R11 after reset", 0, 0, 2'b00, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule